// File: doc/BRIEF.md
# RV32I Subset Single-Cycle Core

This block is a small processor that retires one instruction on every rising clock edge. It handles a subset of the RV32I integer set: the register-immediate operations addi, andi, slti and slli; the register-register operations add, and, xor and slt; the word load and store lw and sw; and the conditional branches beq and bne. The program is a parameter array that is fixed at elaboration and read combinationally through the program counter. The core has thirty-two general registers and a separate data memory made of 32-bit words.

Loads and stores treat their effective address (rs1 plus offset) as the index of a word, not as a byte address. Index 0 is the first data word. The instruction fields use the standard RV32I bit positions, so words produced by an ordinary assembler run unchanged. The core's only outputs are a halt flag and a debug port that reads any register combinationally, so software state is observed through those two.

A two-state controller governs execution. After reset the controller is in ST_RUN, the PC is 0, and each edge commits one instruction. In the edge whose next PC lies at or beyond the end of the program, the RUN_TO_HALT transition moves the controller to ST_HALT. The HALT_HOLD transition keeps it in ST_HALT, where the PC, the registers and the data memory stop changing. A synchronous reset returns the controller to ST_RUN from either state (RESET_TO_RUN).

Top module: `rvs_core`

## Requirements
- R1: Reset is synchronous. The edge that samples rst high sets the PC to 0, clears every register, loads the parameter DATA_WORD0 (default 49) into data word 0 and zero into every other data word, and lowers halt.
- R2: For lw and sw, rs1 plus the sign-extended offset is a word index, and index 0 is the first data word. Reads at an index of DATA_WORDS or above return zero, and writes there are dropped.
- R3: The I-type immediate is bits 31:20, sign-extended from bit 31. Example: 0xfd010113 is addi x2,x2,-48.
- R4: The S-type offset is formed as {bits 31:25, bits 11:7}, sign-extended. Example: 0x02112623 is sw x1,44(x2).
- R5: For slli (funct3 001, bits 31:25 zero), the shift amount is bits 24:20. Example: 0x00169713 is slli x14,x13,1.
- R6: The fixed encodings decode as follows: 0x01550513 is addi x10,x10,21; 0x00657593 is andi x11,x10,6; 0x00b54633 is xor x12,x10,x11; 0x00002683 is lw x13,0(x0); 0x00d77733 is and x14,x14,x13. Opcodes: 0x13 for immediate operations, 0x33 for register operations, 0x03 for lw, 0x23 for sw, 0x63 for branches.
- R7: slt (funct3 010, opcode 0x33) and slti (funct3 010, opcode 0x13) compare as two's-complement signed values and write 1 or 0.
- R8: beq (funct3 000) and bne (funct3 001) compare rs1 with rs2. When taken, the next PC is PC plus the offset {bit 31, bit 7, bits 30:25, bits 11:8, 0}, sign-extended; otherwise it is PC+4. Backward offsets work.
- R9: Register x0 always reads as zero, and writes to it are discarded.
- R10: halt rises in the edge that commits an instruction whose next PC is at or above 4×PROG_LEN. After that, halt stays high and the PC, the registers and the data memory no longer change.
- R11: A register result is written on the rising edge that commits its instruction and can be read on the debug port straight after that edge. Fetch and register reads are combinational in the same cycle.
- R12: With data word 0 holding 49 and all registers zero, the six-instruction program of R6 (ending with slli x14,x13,1 and and x14,x14,x13) leaves x13 = 0x00000031 and x14 = 0x00000020.
- R13: After add x10,x11,x12, the sequence slti x13,x12,0; slt x14,x10,x11; bne x13,x14 branches exactly when the signed addition overflowed. The sequence slli x4,x3,29; beq x4,x0 branches exactly when the low three bits of x3 are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset |
| halt | output | 1 | High once execution has left the program; state is frozen |
| dbg_sel | input | 5 | Register number for the debug read |
| dbg_data | output | 32 | Combinational contents of register dbg_sel (zero for x0) |

## Verification
Every instruction commits on the single edge after it is fetched. Its destination register is therefore due on the debug port immediately after that edge, and halt is due in the edge that commits the last instruction. The bench runs a behavioural instruction-level model that advances one instruction per edge. About 3 ns after each edge it compares halt and the register just written, and it checks hand-derived values at the exact commit counts where the relevant instruction has retired. Stores are observed through later loads, and the frozen state is confirmed by register sweeps taken several cycles after halt.

// File: rtl/rvs_pkg.sv
`timescale 1ns/1ps
package rvs_pkg;

    localparam int unsigned XLEN     = 32;
    localparam int unsigned REG_AW   = 5;
    localparam int unsigned NUM_REGS = 1 << REG_AW;

    localparam logic [6:0] OPC_OPIMM  = 7'h13;
    localparam logic [6:0] OPC_OPREG  = 7'h33;
    localparam logic [6:0] OPC_LOAD   = 7'h03;
    localparam logic [6:0] OPC_STORE  = 7'h23;
    localparam logic [6:0] OPC_BRANCH = 7'h63;

    localparam logic [XLEN-1:0] NOP_WORD = 32'h0000_0013;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_AND,
        ALU_XOR,
        ALU_SLT,
        ALU_SLL
    } alu_op_e;

    typedef enum logic {
        ST_RUN,
        ST_HALT
    } core_state_e;

    typedef struct packed {
        alu_op_e           alu;
        logic              use_imm;
        logic              rf_we;
        logic              mem_rd;
        logic              mem_wr;
        logic              br;
        logic              br_ne;
        logic [REG_AW-1:0] rd;
        logic [REG_AW-1:0] rs1;
        logic [REG_AW-1:0] rs2;
        logic [XLEN-1:0]   imm;
    } dec_t;

endpackage

// File: rtl/rvs_decode.sv
`timescale 1ns/1ps
module rvs_decode
    import rvs_pkg::*;
(
    input  logic [XLEN-1:0] instr,
    output dec_t            dec
);

    logic [6:0]      opc;
    logic [2:0]      f3;
    logic [6:0]      f7;
    logic [XLEN-1:0] imm_i;
    logic [XLEN-1:0] imm_s;
    logic [XLEN-1:0] imm_b;
    logic [XLEN-1:0] imm_sh;

    always_comb begin
        opc    = instr[6:0];
        f3     = instr[14:12];
        f7     = instr[31:25];
        imm_i  = {{20{instr[31]}}, instr[31:20]};
        imm_s  = {{20{instr[31]}}, instr[31:25], instr[11:7]};
        imm_b  = {{19{instr[31]}}, instr[31], instr[7], instr[30:25], instr[11:8], 1'b0};
        imm_sh = {27'd0, instr[24:20]};
    end

    always_comb begin
        dec         = '0;
        dec.alu     = ALU_ADD;
        dec.rd      = instr[11:7];
        dec.rs1     = instr[19:15];
        dec.rs2     = instr[24:20];
        unique case (opc)
            OPC_OPIMM: begin
                dec.use_imm = 1'b1;
                dec.imm     = imm_i;
                unique case (f3)
                    3'b000: begin dec.alu = ALU_ADD; dec.rf_we = 1'b1; end
                    3'b111: begin dec.alu = ALU_AND; dec.rf_we = 1'b1; end
                    3'b010: begin dec.alu = ALU_SLT; dec.rf_we = 1'b1; end
                    3'b001: begin
                        dec.alu   = ALU_SLL;
                        dec.imm   = imm_sh;
                        dec.rf_we = (f7 == 7'd0);
                    end
                    default: dec.rf_we = 1'b0;
                endcase
            end
            OPC_OPREG: begin
                if (f7 == 7'd0) begin
                    unique case (f3)
                        3'b000: begin dec.alu = ALU_ADD; dec.rf_we = 1'b1; end
                        3'b111: begin dec.alu = ALU_AND; dec.rf_we = 1'b1; end
                        3'b100: begin dec.alu = ALU_XOR; dec.rf_we = 1'b1; end
                        3'b010: begin dec.alu = ALU_SLT; dec.rf_we = 1'b1; end
                        default: dec.rf_we = 1'b0;
                    endcase
                end
            end
            OPC_LOAD: begin
                dec.use_imm = 1'b1;
                dec.imm     = imm_i;
                dec.mem_rd  = (f3 == 3'b010);
                dec.rf_we   = (f3 == 3'b010);
            end
            OPC_STORE: begin
                dec.use_imm = 1'b1;
                dec.imm     = imm_s;
                dec.mem_wr  = (f3 == 3'b010);
            end
            OPC_BRANCH: begin
                dec.alu   = ALU_XOR;
                dec.imm   = imm_b;
                dec.br    = (f3 == 3'b000) || (f3 == 3'b001);
                dec.br_ne = (f3 == 3'b001);
            end
            default: dec.rf_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/rvs_regfile.sv
`timescale 1ns/1ps
module rvs_regfile
    import rvs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [REG_AW-1:0] waddr,
    input  logic [XLEN-1:0]   wdata,
    input  logic [REG_AW-1:0] raddr_a,
    input  logic [REG_AW-1:0] raddr_b,
    input  logic [REG_AW-1:0] raddr_dbg,
    output logic [XLEN-1:0]   rdata_a,
    output logic [XLEN-1:0]   rdata_b,
    output logic [XLEN-1:0]   rdata_dbg
);

    logic [XLEN-1:0] regs [NUM_REGS];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_REGS; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    always_comb begin
        rdata_a   = (raddr_a   == '0) ? '0 : regs[raddr_a];
        rdata_b   = (raddr_b   == '0) ? '0 : regs[raddr_b];
        rdata_dbg = (raddr_dbg == '0) ? '0 : regs[raddr_dbg];
    end

endmodule

// File: rtl/rvs_dmem.sv
`timescale 1ns/1ps
module rvs_dmem
    import rvs_pkg::*;
#(
    parameter int unsigned     DEPTH      = 16,
    parameter logic [XLEN-1:0] INIT_WORD0 = 32'd49
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            we,
    input  logic [XLEN-1:0] index,
    input  logic [XLEN-1:0] wdata,
    output logic [XLEN-1:0] rdata
);

    localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [XLEN-1:0] words [DEPTH];
    logic            in_range;

    assign in_range = (index < XLEN'(DEPTH));

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < DEPTH; i++) begin
                words[i] <= (i == 0) ? INIT_WORD0 : '0;
            end
        end else if (we && in_range) begin
            words[index[AW-1:0]] <= wdata;
        end
    end

    assign rdata = in_range ? words[index[AW-1:0]] : '0;

endmodule

// File: rtl/rvs_alu.sv
`timescale 1ns/1ps
module rvs_alu
    import rvs_pkg::*;
(
    input  alu_op_e         op,
    input  logic [XLEN-1:0] a,
    input  logic [XLEN-1:0] b,
    output logic [XLEN-1:0] y
);

    always_comb begin
        unique case (op)
            ALU_ADD: y = a + b;
            ALU_AND: y = a & b;
            ALU_XOR: y = a ^ b;
            ALU_SLT: y = ($signed(a) < $signed(b)) ? XLEN'(1) : '0;
            ALU_SLL: y = a << b[4:0];
            default: y = '0;
        endcase
    end

endmodule

// File: rtl/rvs_core.sv
`timescale 1ns/1ps
module rvs_core
    import rvs_pkg::*;
#(
    parameter int unsigned     PROG_LEN   = 6,
    parameter logic [31:0]     PROG [PROG_LEN] = '{
        32'h01550513, 32'h00657593, 32'h00b54633,
        32'h00002683, 32'h00169713, 32'h00d77733
    },
    parameter int unsigned     DATA_WORDS = 16,
    parameter logic [31:0]     DATA_WORD0 = 32'd49
) (
    input  logic        clk,
    input  logic        rst,
    output logic        halt,
    input  logic [4:0]  dbg_sel,
    output logic [31:0] dbg_data
);

    localparam logic [XLEN-1:0] PROG_END = XLEN'(PROG_LEN * 4);

    core_state_e     state_q;
    core_state_e     state_d;
    logic            commit;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] pc_next;
    logic [XLEN-1:0] instr;
    dec_t            dec;
    logic [XLEN-1:0] rs1_val;
    logic [XLEN-1:0] rs2_val;
    logic [XLEN-1:0] opb;
    logic [XLEN-1:0] alu_y;
    logic [XLEN-1:0] mem_rdata;
    logic [XLEN-1:0] wb_data;
    logic            br_taken;
    logic [XLEN-1:0] br_off;
    logic            rf_we;
    logic            dm_we;

    // Program fetch from the elaboration-time image
    always_comb begin
        instr = NOP_WORD;
        for (int i = 0; i < PROG_LEN; i++) begin
            if (pc_q == XLEN'(i) * XLEN'(4)) begin
                instr = PROG[i];
            end
        end
    end

    rvs_decode u_dec (
        .instr (instr),
        .dec   (dec)
    );

    rvs_regfile u_rf (
        .clk       (clk),
        .rst       (rst),
        .we        (rf_we),
        .waddr     (dec.rd),
        .wdata     (wb_data),
        .raddr_a   (dec.rs1),
        .raddr_b   (dec.rs2),
        .raddr_dbg (dbg_sel),
        .rdata_a   (rs1_val),
        .rdata_b   (rs2_val),
        .rdata_dbg (dbg_data)
    );

    assign opb = dec.use_imm ? dec.imm : rs2_val;

    rvs_alu u_alu (
        .op (dec.alu),
        .a  (rs1_val),
        .b  (opb),
        .y  (alu_y)
    );

    rvs_dmem #(
        .DEPTH      (DATA_WORDS),
        .INIT_WORD0 (DATA_WORD0)
    ) u_dmem (
        .clk   (clk),
        .rst   (rst),
        .we    (dm_we),
        .index (alu_y),
        .wdata (rs2_val),
        .rdata (mem_rdata)
    );

    assign wb_data  = dec.mem_rd ? mem_rdata : alu_y;
    assign br_taken = dec.br & (dec.br_ne ^ (alu_y == '0));
    assign br_off   = dec.imm;
    assign pc_next  = br_taken ? (pc_q + br_off) : (pc_q + XLEN'(4));
    assign rf_we    = commit & dec.rf_we;
    assign dm_we    = commit & dec.mem_wr;

    // State register
    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_RUN;
        end else begin
            state_q <= state_d;
        end
    end

    // Next-state selection
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_RUN:  state_d = (pc_next >= PROG_END) ? ST_HALT : ST_RUN;
            ST_HALT: state_d = ST_HALT;
            default: state_d = ST_HALT;
        endcase
    end

    // Outputs of the controller
    always_comb begin
        commit = 1'b0;
        halt   = 1'b1;
        unique case (state_q)
            ST_RUN:  begin commit = 1'b1; halt = 1'b0; end
            ST_HALT: begin commit = 1'b0; halt = 1'b1; end
            default: begin commit = 1'b0; halt = 1'b1; end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pc_q <= '0;
        end else if (commit) begin
            pc_q <= pc_next;
        end
    end

endmodule

// File: rtl/rvs_core_chk.sv
`timescale 1ns/1ps
module rvs_core_chk (
    input logic        clk,
    input logic        rst,
    input logic        halt,
    input logic [31:0] pc,
    input logic        br_taken,
    input logic [31:0] br_off,
    input logic        rf_we,
    input logic        dm_we,
    input logic [4:0]  dbg_sel,
    input logic [31:0] dbg_data
);

    // R1: first cycle out of reset starts at PC 0, running
    a_r1_reset_start: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (pc == 32'd0 && !halt));

    // R9: register zero never reads non-zero
    a_r9_zero_reg: assert property (@(posedge clk) disable iff (rst)
        (dbg_sel == 5'd0) |-> (dbg_data == 32'd0));

    // R10: halt never drops without reset
    a_r10_halt_sticky: assert property (@(posedge clk) disable iff (rst)
        halt |=> halt);

    // R10: nothing is written while halted
    a_r10_no_writes: assert property (@(posedge clk) disable iff (rst)
        halt |-> (!rf_we && !dm_we));

    // R10: PC frozen while halted
    a_r10_pc_frozen: assert property (@(posedge clk) disable iff (rst)
        halt |=> $stable(pc));

    // R8: sequential flow advances by one word
    a_r8_seq_step: assert property (@(posedge clk) disable iff (rst)
        (!halt && !br_taken) |=> (pc == $past(pc) + 32'd4));

    // R8: taken branch lands on PC plus offset
    a_r8_branch_target: assert property (@(posedge clk) disable iff (rst)
        (!halt && br_taken) |=> (pc == $past(pc) + $past(br_off)));

endmodule

bind rvs_core rvs_core_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .halt     (halt),
    .pc       (pc_q),
    .br_taken (br_taken),
    .br_off   (br_off),
    .rf_we    (rf_we),
    .dm_we    (dm_we),
    .dbg_sel  (dbg_sel),
    .dbg_data (dbg_data)
);

// File: tb/rvs_core_test.sv
`timescale 1ns/1ps
module rvs_core_test;

    localparam logic [6:0] OPI = 7'h13;
    localparam logic [6:0] OPL = 7'h03;
    localparam int TB_LEN = 41;
    localparam int DW     = 16;

    function automatic logic [31:0] enc_i(input int imm, input int rs1, input int f3,
                                          input int rd, input logic [6:0] opc);
        logic [11:0] v;
        v = 12'(imm);
        return {v, 5'(rs1), 3'(f3), 5'(rd), opc};
    endfunction

    function automatic logic [31:0] enc_r(input int rs2, input int rs1, input int f3, input int rd);
        return {7'd0, 5'(rs2), 5'(rs1), 3'(f3), 5'(rd), 7'h33};
    endfunction

    function automatic logic [31:0] enc_s(input int imm, input int rs2, input int rs1);
        logic [11:0] v;
        v = 12'(imm);
        return {v[11:5], 5'(rs2), 5'(rs1), 3'b010, v[4:0], 7'h23};
    endfunction

    function automatic logic [31:0] enc_b(input int imm, input int rs1, input int rs2, input int f3);
        logic [12:0] v;
        v = 13'(imm);
        return {v[12], v[10:5], 5'(rs2), 5'(rs1), 3'(f3), v[4:1], v[11], 7'h63};
    endfunction

    localparam logic [31:0] TB_PROG [TB_LEN] = '{
        32'h01550513, 32'h00657593, 32'h00b54633, 32'h00002683,
        32'h00169713, 32'h00d77733,
        enc_i(8, 0, 0, 2, OPI),
        32'hfd010113,
        enc_i(77, 0, 0, 1, OPI),
        32'h02112623,
        enc_i(4, 0, 2, 15, OPL),
        enc_i(1, 0, 0, 5, OPI),
        enc_i(30, 5, 1, 5, OPI),
        enc_r(0, 5, 0, 11),
        enc_r(0, 5, 0, 12),
        enc_r(12, 11, 0, 10),
        enc_i(0, 12, 2, 13, OPI),
        enc_r(11, 10, 2, 14),
        enc_b(8, 13, 14, 1),
        enc_i(1, 0, 0, 16, OPI),
        enc_i(2, 0, 0, 17, OPI),
        enc_i(5, 0, 0, 12, OPI),
        enc_r(12, 11, 0, 10),
        enc_i(0, 12, 2, 13, OPI),
        enc_r(11, 10, 2, 14),
        enc_b(8, 13, 14, 1),
        enc_i(3, 0, 0, 18, OPI),
        enc_i(24, 0, 0, 3, OPI),
        enc_i(29, 3, 1, 4, OPI),
        enc_b(8, 4, 0, 0),
        enc_i(1, 0, 0, 19, OPI),
        enc_i(13, 0, 0, 3, OPI),
        enc_i(29, 3, 1, 4, OPI),
        enc_b(8, 4, 0, 0),
        enc_i(1, 0, 0, 20, OPI),
        enc_i(3, 0, 0, 21, OPI),
        enc_i(-1, 21, 0, 21, OPI),
        enc_b(-4, 21, 0, 1),
        enc_i(5, 0, 0, 0, OPI),
        enc_s(0, 17, 0),
        enc_i(0, 0, 2, 23, OPL)
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        halt;
    logic [4:0]  dbg_sel = 5'd0;
    logic [31:0] dbg_data;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;

    logic [31:0] m_regs [32];
    logic [31:0] m_mem  [DW];
    logic [31:0] m_pc;
    bit          m_halt;

    always #4 clk = ~clk;

    rvs_core #(
        .PROG_LEN   (TB_LEN),
        .PROG       (TB_PROG),
        .DATA_WORDS (DW),
        .DATA_WORD0 (32'd49)
    ) uut (
        .clk      (clk),
        .rst      (rst),
        .halt     (halt),
        .dbg_sel  (dbg_sel),
        .dbg_data (dbg_data)
    );

    task automatic check(input string req, input string what, input logic [31:0] act,
                         input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%08h expected 0x%08h", req, what, act, exp);
        end
    endtask

    task automatic peek(input int r, input string req, input logic [31:0] exp);
        dbg_sel = 5'(r);
        #1;
        check(req, $sformatf("x%0d", r), dbg_data, exp);
    endtask

    task automatic sweep(input string req);
        for (int r = 0; r < 32; r++) begin
            @(negedge clk);
            peek(r, req, m_regs[r]);
        end
    endtask

    // Behavioural instruction-level reference: one instruction per edge
    task automatic model_step(output int wr_rd);
        logic [31:0] w, a, b, ii, si, bi, res, nxt, addr;
        int          idx;
        bit          wr;
        idx = int'(m_pc >> 2);
        w = (m_pc[1:0] == 2'b00 && idx < TB_LEN) ? TB_PROG[idx] : 32'h13;
        a  = m_regs[w[19:15]];
        b  = m_regs[w[24:20]];
        ii = {{20{w[31]}}, w[31:20]};
        si = {{20{w[31]}}, w[31:25], w[11:7]};
        bi = {{19{w[31]}}, w[31], w[7], w[30:25], w[11:8], 1'b0};
        nxt = m_pc + 4;
        wr  = 1'b0;
        res = 32'd0;
        case (w[6:0])
            7'h13: begin
                wr = 1'b1;
                case (w[14:12])
                    3'd0: res = a + ii;
                    3'd7: res = a & ii;
                    3'd2: res = ($signed(a) < $signed(ii)) ? 32'd1 : 32'd0;
                    3'd1: res = a << w[24:20];
                    default: wr = 1'b0;
                endcase
            end
            7'h33: begin
                wr = 1'b1;
                case (w[14:12])
                    3'd0: res = a + b;
                    3'd7: res = a & b;
                    3'd4: res = a ^ b;
                    3'd2: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
                    default: wr = 1'b0;
                endcase
            end
            7'h03: begin
                addr = a + ii;
                res  = (addr < DW) ? m_mem[addr[3:0]] : 32'd0;
                wr   = 1'b1;
            end
            7'h23: begin
                addr = a + si;
                if (addr < DW) m_mem[addr[3:0]] = b;
            end
            7'h63: begin
                if (w[14:12] == 3'd0 && a == b) nxt = m_pc + bi;
                if (w[14:12] == 3'd1 && a != b) nxt = m_pc + bi;
            end
            default: wr = 1'b0;
        endcase
        wr_rd = 0;
        if (wr) begin
            wr_rd = int'(w[11:7]);
            if (wr_rd != 0) m_regs[wr_rd] = res;
        end
        m_pc = nxt;
        if (m_pc >= 32'(TB_LEN * 4)) m_halt = 1'b1;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin : main
        int rd;
        int retired;
        for (int r = 0; r < 32; r++) m_regs[r] = 32'd0;
        for (int i = 0; i < DW; i++) m_mem[i] = 32'd0;
        m_mem[0] = 32'd49;
        m_pc     = 32'd0;
        m_halt   = 1'b0;
        retired  = 0;

        repeat (2) @(posedge clk);
        // R1: reset state, held while rst is high
        sweep("R1");
        check("R1", "halt in reset", {31'd0, halt}, 32'd0);
        @(negedge clk);
        rst = 1'b0;

        while (!m_halt && retired < 2000) begin
            @(posedge clk);
            model_step(rd);
            retired++;
            #3;
            check("R10", $sformatf("halt after commit %0d", retired), {31'd0, halt}, {31'd0, m_halt});
            // R11: result visible right after its commit edge
            peek(rd, "R11", m_regs[rd]);
            case (retired)
                2:  peek(11, "R6", 32'd4);
                3:  peek(12, "R6", 32'd17);
                4:  peek(13, "R2", 32'd49);
                6:  begin peek(13, "R12", 32'h31); peek(14, "R12", 32'h20); end
                8:  peek(2, "R3", 32'hFFFF_FFD8);
                11: peek(15, "R4", 32'd77);
                18: peek(14, "R7", 32'd1);
                default: ;
            endcase
        end

        sweep("R11");
        @(negedge clk);
        peek(0,  "R9",  32'd0);
        peek(4,  "R5",  32'hA000_0000);
        peek(16, "R13", 32'd0);
        peek(17, "R8",  32'd2);
        @(negedge clk);
        peek(18, "R13", 32'd3);
        peek(19, "R13", 32'd0);
        peek(20, "R13", 32'd1);
        @(negedge clk);
        peek(21, "R8",  32'd0);
        peek(23, "R2",  32'd2);
        peek(10, "R7",  32'h4000_0005);

        repeat (5) @(posedge clk);
        #3;
        check("R10", "halt held", {31'd0, halt}, 32'd1);
        sweep("R10");

        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule